// File: doc/BRIEF.md
# Multi-Width Rotate-Right-Through-Carry Unit

This block performs a single-position right rotation through a carry flag on an operand held in a 20-bit word. The operand may be treated as 8, 16 or 20 bits wide: the incoming carry enters the top bit of the selected field, every bit of the field moves one place toward bit 0, and the bit shifted out of bit 0 becomes the outgoing carry. Sign, zero, carry and overflow flags are derived from the selected field.

When the operand comes from a register, the bits above the selected field are forced to zero. When it comes from memory, those bits pass through from the input unchanged, so the caller can write back the whole word and only the sized field is modified. The caller presents one operation per strobe, and the result and flags appear registered one clock later with a single-cycle done pulse. They then hold until the next strobe.

Top module: `rrc_unit`

## Requirements
- R1: One clock edge after a cycle with `in_valid` high, `out_done` is high for exactly one cycle. It is low in every cycle that does not follow a strobe.
- R2: Full size (20 bits): `out_word = {in_carry, in_word[19:1]}` and `flag_c = in_word[0]`. For example, with carry 1, an operand of 12345h gives 891A2h.
- R3: Half size (16 bits): `out_word[15:0] = {in_carry, in_word[15:1]}` and `flag_c = in_word[0]`.
- R4: Byte size (8 bits): `out_word[7:0] = {in_carry, in_word[7:1]}` and `flag_c = in_word[0]`.
- R5: The size code `in_size` selects the width as follows: 2'b00 is byte, 2'b01 is half and 2'b10 is full. The code 2'b11 behaves the same as full.
- R6: When `in_regmode` is 1, a half-size result has bits 19:16 equal to zero, and a byte-size result has bits 19:8 equal to zero.
- R7: When `in_regmode` is 0, the result bits above the selected width equal the corresponding input bits.
- R8: `flag_n` equals the top bit of the selected field of the result: bit 19, bit 15 or bit 7.
- R9: `flag_z` is 1 exactly when the selected field of the result is all zero.
- R10: `flag_v` is 0 after every operation.
- R11: While `in_valid` is low, `out_word` and all four flags keep their values.
- R12: A synchronous active-high `rst` clears `out_word`, all flags and `out_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| in_word | input | 20 | Operand word |
| in_carry | input | 1 | Incoming carry |
| in_size | input | 2 | Operand width code |
| in_regmode | input | 1 | 1 = register operand (upper bits cleared) |
| out_done | output | 1 | One-cycle result-valid pulse |
| out_word | output | 20 | Result word |
| flag_n | output | 1 | Sign of the sized result |
| flag_z | output | 1 | Sized result is zero |
| flag_c | output | 1 | Bit shifted out of bit 0 |
| flag_v | output | 1 | Overflow, always cleared |

## Verification
The bench drives every size code, including the alias code 2'b11, with both carry values and both operand sources. The operands are chosen so that the bits at each field boundary differ from their neighbours. A design that took the sign from bit 19 for every size, or that tested zero across the whole word, fails on operands whose upper bits are set while the field below is zero or positive. A design that cleared the upper bits in memory mode, or kept them in register mode, shows the wrong upper nibble or byte. Idle gaps between strobes and back-to-back strobes expose a design whose flags drift without a strobe or whose done pulse is stretched.

// File: rtl/rrc_pkg.sv
package rrc_pkg;

    // Width codes presented on in_size
    typedef enum logic [1:0] {
        SZ_BYTE  = 2'b00,
        SZ_HALF  = 2'b01,
        SZ_FULL  = 2'b10,
        SZ_FULL2 = 2'b11
    } rrc_size_e;

    // Number of selectable widths
    localparam int unsigned NUM_SIZES = 3;

endpackage

// File: rtl/rrc_size_decode.sv
// Turns the width code into a one-hot select: [0]=byte, [1]=half, [2]=full.
module rrc_size_decode
    import rrc_pkg::*;
(
    input  logic [1:0]           size_code,
    output logic [NUM_SIZES-1:0] size_sel
);
    always_comb begin
        size_sel = '0;
        unique case (rrc_size_e'(size_code))
            SZ_BYTE:  size_sel[0] = 1'b1;
            SZ_HALF:  size_sel[1] = 1'b1;
            SZ_FULL,
            SZ_FULL2: size_sel[2] = 1'b1;
            default:  size_sel[2] = 1'b1;
        endcase
    end

    // R5
    sel_onehot_chk: assert final ($onehot(size_sel));
endmodule

// File: rtl/rrc_rotate.sv
// One candidate per width, chosen through the one-hot select.
module rrc_rotate
    import rrc_pkg::*;
#(
    parameter int unsigned FULL_W = 20,
    parameter int unsigned HALF_W = 16,
    parameter int unsigned BYTE_W = 8
) (
    input  logic [FULL_W-1:0]    op,
    input  logic                 cin,
    input  logic                 regmode,
    input  logic [NUM_SIZES-1:0] sel,
    output logic [FULL_W-1:0]    result,
    output logic                 cout
);
    logic [FULL_W-1:0] cand [NUM_SIZES];

    for (genvar g = 0; g < NUM_SIZES; g++) begin : g_width
        localparam int unsigned W = (g == 0) ? BYTE_W : (g == 1) ? HALF_W : FULL_W;
        if (W == FULL_W) begin : g_top
            assign cand[g] = {cin, op[FULL_W-1:1]};
        end else begin : g_part
            logic [FULL_W-W-1:0] upper;
            assign upper   = regmode ? '0 : op[FULL_W-1:W];
            assign cand[g] = {upper, cin, op[W-1:1]};
        end
    end

    always_comb begin
        result = '0;
        for (int g = 0; g < NUM_SIZES; g++) begin
            result |= cand[g] & {FULL_W{sel[g]}};
        end
    end

    // The outgoing carry is bit 0 for every width
    assign cout = op[0];
endmodule

// File: rtl/rrc_flag_gen.sv
// Sign and zero of the selected field of the result.
module rrc_flag_gen
    import rrc_pkg::*;
#(
    parameter int unsigned FULL_W = 20,
    parameter int unsigned HALF_W = 16,
    parameter int unsigned BYTE_W = 8
) (
    input  logic [FULL_W-1:0]    result,
    input  logic [NUM_SIZES-1:0] sel,
    output logic                 neg,
    output logic                 zero
);
    logic [NUM_SIZES-1:0] top_bit;
    logic [NUM_SIZES-1:0] field_zero;

    for (genvar g = 0; g < NUM_SIZES; g++) begin : g_width
        localparam int unsigned W = (g == 0) ? BYTE_W : (g == 1) ? HALF_W : FULL_W;
        assign top_bit[g]    = result[W-1];
        assign field_zero[g] = (result[W-1:0] == '0);
    end

    assign neg  = |(top_bit & sel);
    assign zero = |(field_zero & sel);
endmodule

// File: rtl/rrc_unit.sv
module rrc_unit
    import rrc_pkg::*;
#(
    parameter int unsigned FULL_W = 20,
    parameter int unsigned HALF_W = 16,
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [FULL_W-1:0] in_word,
    input  logic              in_carry,
    input  logic [1:0]        in_size,
    input  logic              in_regmode,
    output logic              out_done,
    output logic [FULL_W-1:0] out_word,
    output logic              flag_n,
    output logic              flag_z,
    output logic              flag_c,
    output logic              flag_v
);
    typedef struct packed {
        logic [FULL_W-1:0] word;
        logic              n;
        logic              z;
        logic              c;
        logic              v;
        logic              done;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_SIZES-1:0] sel;
    logic [FULL_W-1:0]    rot_word;
    logic                 rot_c, rot_n, rot_z;

    rrc_size_decode u_dec (
        .size_code (in_size),
        .size_sel  (sel)
    );

    rrc_rotate #(.FULL_W(FULL_W), .HALF_W(HALF_W), .BYTE_W(BYTE_W)) u_rot (
        .op      (in_word),
        .cin     (in_carry),
        .regmode (in_regmode),
        .sel     (sel),
        .result  (rot_word),
        .cout    (rot_c)
    );

    rrc_flag_gen #(.FULL_W(FULL_W), .HALF_W(HALF_W), .BYTE_W(BYTE_W)) u_flg (
        .result (rot_word),
        .sel    (sel),
        .neg    (rot_n),
        .zero   (rot_z)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = in_valid;
        if (in_valid) begin
            st_d.word = rot_word;
            st_d.n    = rot_n;
            st_d.z    = rot_z;
            st_d.c    = rot_c;
            st_d.v    = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign out_done = st_q.done;
    assign out_word = st_q.word;
    assign flag_n   = st_q.n;
    assign flag_z   = st_q.z;
    assign flag_c   = st_q.c;
    assign flag_v   = st_q.v;

    // R1
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_done);
    // R1
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_done);
    // R2
    carry_out_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> flag_c == $past(in_word[0]));
    // R8
    sign_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> flag_n == $past(in_carry));
    // R6
    byte_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_regmode && in_size == 2'b00) |=> out_word[FULL_W-1:BYTE_W] == '0);
    // R11
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_word) && $stable({flag_n, flag_z, flag_c, flag_v}));
endmodule

// File: tb/rrc_unit_bench.sv
module rrc_unit_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [19:0] in_word;
    logic        in_carry;
    logic [1:0]  in_size;
    logic        in_regmode;
    logic        out_done;
    logic [19:0] out_word;
    logic        flag_n, flag_z, flag_c, flag_v;

    always #5 clk = ~clk;

    rrc_unit u_rrc_unit (
        .clk, .rst, .in_valid, .in_word, .in_carry, .in_size, .in_regmode,
        .out_done, .out_word, .flag_n, .flag_z, .flag_c, .flag_v
    );

    typedef struct {
        logic [23:0] exp;   // {word, n, z, c, v}
        string       tag;
    } item_t;

    item_t       sb[$];
    int          n_cmp = 0;
    int          n_bad = 0;
    logic [23:0] last_exp = '0;
    bit          finished = 0;

    function automatic logic [23:0] model(input logic [19:0] w, input logic c,
                                          input logic [1:0] sz, input logic rm);
        int          wd;
        logic [19:0] r;
        wd = (sz == 2'b00) ? 8 : (sz == 2'b01) ? 16 : 20;
        r  = w;
        for (int i = 0; i < wd - 1; i++) r[i] = w[i+1];
        r[wd-1] = c;
        if (rm) for (int i = wd; i < 20; i++) r[i] = 1'b0;
        return {r, r[wd-1], ((r & ((20'h1 << wd) - 20'h1)) == 20'h0), w[0], 1'b0};
    endfunction

    function automatic string tag_of(input logic [1:0] sz, input logic rm);
        string s;
        s = (sz == 2'b00) ? "R4 R5" : (sz == 2'b01) ? "R3 R5" : "R2 R5";
        s = {s, rm ? " R6" : " R7", " R8 R9 R10"};
        return s;
    endfunction

    task automatic check(input logic [23:0] act, input logic [23:0] exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual word=%h nzcv=%b expected word=%h nzcv=%b",
                     tag, act[23:4], act[3:0], exp[23:4], exp[3:0]);
        end
    endtask

    // Driver: inputs change on the falling edge
    task automatic drive(input logic [19:0] w, input logic c, input logic [1:0] sz, input logic rm);
        item_t it;
        @(negedge clk);
        in_valid = 1'b1; in_word = w; in_carry = c; in_size = sz; in_regmode = rm;
        it.exp = model(w, c, sz, rm);
        it.tag = tag_of(sz, rm);
        sb.push_back(it);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // Monitor: compares on the falling edge after the result register updates
    always @(negedge clk) begin
        if (!rst && !finished) begin
            if (out_done) begin
                if (sb.size() == 0) begin
                    check({out_done, 23'h0}, 24'h0, "R1 unexpected done");
                end else begin
                    item_t it;
                    it = sb.pop_front();
                    check({out_word, flag_n, flag_z, flag_c, flag_v}, it.exp, it.tag);
                    last_exp = it.exp;
                end
            end
        end
    end

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    logic [19:0] pats [8] = '{20'h00000, 20'h00001, 20'hFFFFF, 20'hA5A5A,
                              20'h12345, 20'hF0100, 20'h0FF00, 20'h10000};

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_word = '1; in_carry = 1'b1;
        in_size = 2'b10; in_regmode = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12: reset state
        check({out_word, flag_n, flag_z, flag_c, flag_v}, 24'h0, "R12 reset word/flags");
        check({out_done, 23'h0}, 24'h0, "R12 reset done");

        // R2: worked example, carry in sets bit 19
        drive(20'h12345, 1'b1, 2'b10, 1'b1);
        idle(1);
        @(negedge clk);
        check({out_word, 4'h0}, {20'h891A2, 4'h0}, "R2 example word");
        // R1: done lasts one cycle
        check({out_done, 23'h0}, 24'h0, "R1 done single cycle");

        // Full sweep with idle gaps
        for (int sz = 0; sz < 4; sz++)
            for (int rm = 0; rm < 2; rm++)
                for (int c = 0; c < 2; c++)
                    for (int p = 0; p < 8; p++) begin
                        drive(pats[p], c[0], sz[1:0], rm[0]);
                        idle(p % 3);
                    end
        idle(3);

        // R11: values held across an idle stretch
        idle(5);
        @(negedge clk);
        check({out_word, flag_n, flag_z, flag_c, flag_v}, last_exp, "R11 hold while idle");

        // Back-to-back strobes (R1)
        drive(20'hFF00F, 1'b0, 2'b00, 1'b0);
        drive(20'h00101, 1'b1, 2'b01, 1'b1);
        drive(20'h00002, 1'b0, 2'b11, 1'b0);
        idle(4);

        // R12: reset clears after activity
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check({out_word, flag_n, flag_z, flag_c, flag_v}, 24'h0, "R12 reset after use");

        check({sb.size() != 0, 23'h0}, 24'h0, "R1 all results delivered");
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule